// File: doc/BRIEF.md
# Grouped Interrupt Expansion Controller

This block gathers a large set of peripheral interrupt sources, arranged as `NGRP` groups of `NSRC` sources, and folds them onto one CPU interrupt line per group. Each source has a flag, which its source pulse sets, and an enable. A group counts as pending when at least one source is both flagged and enabled. A group can raise its CPU line only after software has armed it by writing a one to that group's bit in the acknowledge register. Each arming produces at most one single-cycle pulse.

When the CPU takes a group's interrupt, it runs a vector fetch. The block answers in the same cycle with a vector-table address for the lowest-numbered source in the group that is both flagged and enabled. At the next clock edge it clears that one flag and records the address. Software reads the recorded address from the upper fifteen bits of the control register. Bit 0 of that register turns expansion fetches on. While it is off, fetches are not answered and no flag is touched. All registers stay accessible in either state.

Top module: `grp_irq_expander`

## Requirements
- R1: After reset, every register reads zero, `cpu_irq` is zero and `fetch_hit` is low.
- R2: A one on `src_irq[g*NSRC+s]` at a clock edge sets the flag of source s in group g. That flag reads back at bit s of the group's flag register at address 2+2g. Bits 15:NSRC of that register read zero.
- R3: A bus write to a flag register loads the written low bits, so a 0 clears a flag and a 1 sets it. When a source pulses in the same cycle that software writes 0 to its flag, the flag ends up set.
- R4: The enable register of group g, at address 3+2g, is read/write in bits NSRC-1:0. Its upper bits read zero.
- R5: Reading the acknowledge register (address 1) returns one bit per group, bit g, which is 1 when group g is pending. Writing a 1 to bit g arms group g. Writing a 0 changes nothing.
- R6: An armed, pending group drives its `cpu_irq` bit high for exactly one cycle, in the cycle after the edge where both conditions hold. The pulse consumes the arming, so no further pulse comes until software arms the group again.
- R7: With the control bit set, a `fetch_req` for a group with pending sources raises `fetch_hit` in the same cycle. `fetch_addr` is then VEC_BASE + 2*(NSRC*group + source), where source is the lowest pending enabled index. At the next edge only that source's flag is cleared.
- R8: With control bit 0 clear, or with a group number of NGRP or above, `fetch_hit` stays low and no flag is cleared.
- R9: Control register (address 0) bits 15:1 show bits 15:1 of the last hit's `fetch_addr`. A bus write changes only bit 0.
- R10: A flagged source whose enable bit is 0 does not make its group pending and never causes a CPU pulse, even when the group is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_irq | input | NGRP*NSRC | Source event pulses, group-major |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| cpu_irq | output | NGRP | One-cycle interrupt pulse per group |
| fetch_req | input | 1 | CPU vector fetch request |
| fetch_grp | input | GW | Group being fetched |
| fetch_hit | output | 1 | Expansion vector supplied this cycle |
| fetch_addr | output | 16 | Vector-table address of the winning source |

## Verification
A corrupted flag or enable bit shows up at once on the acknowledge readback, and it also shows up in the next fetch's address. A wrong winner choice produces a `fetch_addr` that is off by a multiple of two in that same cycle, and one cycle later the wrong flag bit reads back cleared. A stale or never-consumed arming state shows up as a missing pulse, or a second `cpu_irq` pulse, within two cycles of the arming write. For that reason the bench samples the pulse cycle by cycle around every acknowledge write.

// File: rtl/grp_irq_expander.sv
module grp_irq_expander #(
  parameter int NGRP = 12,
  parameter int NSRC = 8,
  parameter logic [15:0] VEC_BASE = 16'h0400,
  localparam int GW = $clog2(NGRP),
  localparam int SW = $clog2(NSRC),
  localparam int AW = $clog2(2*NGRP+2)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NGRP*NSRC-1:0] src_irq,
  input  logic                 bus_wr,
  input  logic [AW-1:0]        bus_addr,
  input  logic [15:0]          bus_wdata,
  output logic [15:0]          bus_rdata,
  output logic [NGRP-1:0]      cpu_irq,
  input  logic                 fetch_req,
  input  logic [GW-1:0]        fetch_grp,
  output logic                 fetch_hit,
  output logic [15:0]          fetch_addr
);

  logic [NGRP-1:0][NSRC-1:0] flag_q, en_q;
  logic [NGRP-1:0]           allow_q, pend, en_any;
  logic                      ctl_en_q;
  logic [14:0]               vec_q;
  logic [NSRC-1:0]           fmask;
  logic [SW-1:0]             win;
  logic                      any;

  wire wr_ctl = bus_wr && (bus_addr == AW'(0));
  wire wr_ack = bus_wr && (bus_addr == AW'(1));

  always_comb begin
    fmask = '0;
    for (int g = 0; g < NGRP; g++)
      if (fetch_grp == GW'(g)) fmask = flag_q[g] & en_q[g];
    win = '0;
    any = 1'b0;
    for (int i = NSRC-1; i >= 0; i--)
      if (fmask[i]) begin
        win = SW'(i);
        any = 1'b1;
      end
  end

  assign fetch_hit  = fetch_req && ctl_en_q && any;
  assign fetch_addr = VEC_BASE + ((16'(fetch_grp) * 16'(NSRC) + 16'(win)) << 1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_en_q <= 1'b0;
      vec_q    <= '0;
    end else begin
      if (wr_ctl) ctl_en_q <= bus_wdata[0];
      if (fetch_hit) vec_q <= fetch_addr[15:1];
    end
  end

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    wire [NSRC-1:0] src  = src_irq[g*NSRC +: NSRC];
    wire            wr_f = bus_wr && (bus_addr == AW'(2 + 2*g));
    wire            wr_e = bus_wr && (bus_addr == AW'(3 + 2*g));
    wire [NSRC-1:0] clr  = (fetch_hit && fetch_grp == GW'(g)) ? (NSRC'(1) << win) : '0;
    wire            fire = allow_q[g] && pend[g];

    assign pend[g]   = |(flag_q[g] & en_q[g]);
    assign en_any[g] = |en_q[g];

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        flag_q[g]  <= '0;
        en_q[g]    <= '0;
        allow_q[g] <= 1'b0;
        cpu_irq[g] <= 1'b0;
      end else begin
        if (wr_f) flag_q[g] <= bus_wdata[NSRC-1:0] | src;
        else      flag_q[g] <= (flag_q[g] & ~clr) | src;
        if (wr_e) en_q[g] <= bus_wdata[NSRC-1:0];
        allow_q[g] <= (allow_q[g] && !fire) || (wr_ack && bus_wdata[g]);
        cpu_irq[g] <= fire;
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == AW'(0)) bus_rdata = {vec_q, ctl_en_q};
    else if (bus_addr == AW'(1)) bus_rdata[NGRP-1:0] = pend;
    else
      for (int g = 0; g < NGRP; g++) begin
        if (bus_addr == AW'(2 + 2*g)) bus_rdata[NSRC-1:0] = flag_q[g];
        if (bus_addr == AW'(3 + 2*g)) bus_rdata[NSRC-1:0] = en_q[g];
      end
  end

  assert_flag_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ($past(src_irq) & ~flag_q) == '0);

  assert_irq_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_irq & $past(cpu_irq)) == '0);

  assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (cpu_irq & ~$past(en_any)) == '0);

  assert_vec_record_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hit |=> vec_q == $past(fetch_addr[15:1]));

  assert_hit_needs_ctl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hit |-> ctl_en_q && fetch_grp < GW'(NGRP));

  assert_addr_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_hit |-> fetch_addr >= VEC_BASE && fetch_addr < VEC_BASE + 16'(2*NGRP*NSRC) && !fetch_addr[0]);

endmodule

// File: tb/grp_irq_expander_tb_top.sv
`timescale 1ns/1ps
module grp_irq_expander_tb_top;
  localparam int NGRP = 12, NSRC = 8, GW = 4, AW = 5;
  localparam logic [15:0] BASE = 16'h0400;

  logic clk = 0, rst_n = 0;
  logic [NGRP*NSRC-1:0] src_irq = '0;
  logic bus_wr = 0;
  logic [AW-1:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0, bus_rdata;
  logic [NGRP-1:0] cpu_irq;
  logic fetch_req = 0;
  logic [GW-1:0] fetch_grp = '0;
  logic fetch_hit;
  logic [15:0] fetch_addr;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  grp_irq_expander dut_i (.clk, .rst_n, .src_irq, .bus_wr, .bus_addr, .bus_wdata,
    .bus_rdata, .cpu_irq, .fetch_req, .fetch_grp, .fetch_hit, .fetch_addr);

  // {group, source mask, winning source}
  localparam logic [23:0] TBL [9] = '{
    {8'd0, 8'h01, 8'd0}, {8'd1, 8'h80, 8'd7}, {8'd2, 8'h0C, 8'd2},
    {8'd5, 8'hF0, 8'd4}, {8'd7, 8'h81, 8'd0}, {8'd9, 8'h28, 8'd3},
    {8'd11, 8'hFF, 8'd0}, {8'd11, 8'h40, 8'd6}, {8'd3, 8'h06, 8'd1}};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(int a, logic [15:0] d);
    bus_wr = 1; bus_addr = AW'(a); bus_wdata = d;
    tick();
    bus_wr = 0;
  endtask

  task automatic rd(int a, output logic [15:0] d);
    bus_addr = AW'(a); #0.5; d = bus_rdata;
  endtask

  task automatic pulse(int g, logic [7:0] m);
    src_irq[g*NSRC +: NSRC] = m;
    tick();
    src_irq = '0;
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    @(negedge clk); tick(); tick();
    rst_n = 1;
    // R1 reset state
    for (int a = 0; a < 2*NGRP+2; a++) begin
      rd(a, d); chk("R1", d, 0);
    end
    chk("R1 irq", cpu_irq, 0);
    fetch_req = 1; fetch_grp = 0; #0.5; chk("R1 hit", fetch_hit, 0); fetch_req = 0;

    // R4 enable readback, upper bits zero
    for (int g = 0; g < NGRP; g++) wr(3+2*g, 16'hFFFF);
    rd(3+2*5, d); chk("R4", d, 16'h00FF);

    // R8 disabled fetch leaves flag
    pulse(10, 8'h04);
    rd(2+2*10, d); chk("R2", d, 16'h0004);
    fetch_req = 1; fetch_grp = 10; #0.5; chk("R8 hit", fetch_hit, 0);
    tick(); fetch_req = 0;
    rd(2+2*10, d); chk("R8 flag", d, 16'h0004);
    wr(2+2*10, 0);
    rd(2+2*10, d); chk("R3 clear", d, 0);

    wr(0, 16'hFFFF);
    rd(0, d); chk("R9 write bit0 only", d, 16'h0001);

    // R8 out-of-range group
    fetch_req = 1; fetch_grp = 4'd12; #0.5; chk("R8 range", fetch_hit, 0);
    tick(); fetch_req = 0;

    // R7 table of fetches
    foreach (TBL[k]) begin
      int g; logic [7:0] m; int w; logic [15:0] ea;
      g = int'(TBL[k][23:16]); m = TBL[k][15:8]; w = int'(TBL[k][7:0]);
      ea = BASE + 16'(2*(8*g + w));
      pulse(g, m);
      rd(2+2*g, d); chk("R2 table", d, {8'h0, m});
      fetch_req = 1; fetch_grp = GW'(g); #0.5;
      chk("R7 hit", fetch_hit, 1);
      chk("R7 addr", fetch_addr, ea);
      tick(); fetch_req = 0;
      rd(2+2*g, d); chk("R7 only winner", d, {8'h0, m & ~(8'h1 << w)});
      rd(0, d); chk("R9 vector", d, {ea[15:1], 1'b1});
      wr(2+2*g, 0);
    end

    // R3 write 1 sets, simultaneous source beats write 0
    wr(2+2*8, 16'h0011);
    rd(2+2*8, d); chk("R3 set", d, 16'h0011);
    src_irq[8*NSRC+2] = 1; wr(2+2*8, 0); src_irq = '0;
    rd(2+2*8, d); chk("R3 hw wins", d, 16'h0004);
    wr(2+2*8, 0);

    // R10 masked source never pulses
    wr(3+2*6, 16'h00FE);
    pulse(6, 8'h01);
    rd(2+2*6, d); chk("R10 flag", d, 16'h0001);
    rd(1, d); chk("R10 not pending", d[6], 0);
    wr(1, 16'h0040);
    for (int i = 0; i < 3; i++) begin chk("R10 no irq", cpu_irq, 0); tick(); end

    // R5/R6 on group 4
    pulse(4, 8'h02);
    rd(1, d); chk("R5 pending", d, 16'h0010);
    wr(1, 16'h0000);
    chk("R5 write0", cpu_irq, 0); tick(); chk("R5 write0", cpu_irq, 0);
    wr(1, 16'h0010);
    chk("R6 before", cpu_irq, 0);
    tick(); chk("R6 pulse", cpu_irq, 12'h010);
    tick(); chk("R6 single", cpu_irq, 0);
    tick(); chk("R6 consumed", cpu_irq, 0);
    wr(1, 16'h0010);
    tick(); chk("R6 rearm", cpu_irq, 12'h010);
    tick(); chk("R6 single2", cpu_irq, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule